// File: doc/BRIEF.md
# IDE Controller Configuration Space with Compatibility and Native Modes

This block is the PCI configuration register file of a two-channel IDE controller. It answers 32-bit configuration reads and writes and honours byte enables on every dword. It holds the identification words, a command word, the class-code dword with its programming-interface byte, five I/O base address registers and the interrupt-line byte. It turns that state into the I/O base addresses the channel decoders use, the bus-master DMA base, and the interrupt routing for each channel.

Each channel runs in compatibility mode or in native mode, as its bit in the programming-interface byte selects. A channel in compatibility mode decodes at its fixed legacy ports and raises its own legacy interrupt line. Its two base registers are hidden from software: they read as zero and writes to them are dropped. A channel in native mode exposes writable base registers and decodes at the addresses programmed there. Its legacy line is released, and its request is sent to the shared PCI INTx output, which the command word can mask.

Top module: `ide_cfg_space`

## Requirements
- R1: After reset the class dword (dword 2) reads {8'h01, 8'h01, 8'h8A, REV}. The programming-interface byte is bits [15:8] and its value 0x8A places both channels in compatibility mode. The identification dword (dword 0) reads {DEV_ID, VEN_ID}.
- R2: While a channel is in compatibility mode, reads of its two base registers return 0 and writes to them leave the stored value unchanged. The primary channel owns dwords 4 and 5 and the secondary channel owns dwords 6 and 7.
- R3: A channel in compatibility mode decodes at fixed bases: primary command 0x1F0, primary control 0x3F4, secondary command 0x170 and secondary control 0x374.
- R4: A channel in native mode has writable base registers. Bit 0 reads 1, bits above IO_AW-1 read 0, and the address bits below the block size read 0 (8 bytes for a command block, 4 bytes for a control block). The decoded base equals the register value with bit 0 cleared.
- R5: The bus-master DMA base (dword 8) resets to 0xCC01. It is writable in either mode, has a 16-byte size, and drives dma_base with bit 0 cleared.
- R6: Programming-interface bit 0 (primary native) and bit 2 (secondary native) are writable only when bit 1 or bit 3 respectively, the programmable indicator, is set. All other bits of that byte are read-only.
- R7: A write changes only the bytes whose byte enable is set.
- R8: Reset loads the native-mode base registers with 0x1F1, 0x3F5, 0x171 and 0x375. These values are the ones seen when a channel first switches to native mode.
- R9: In compatibility mode a channel's legacy interrupt line follows its request and its drive enable is 1. In native mode that line's drive enable is 0 and the line is 0.
- R10: inta is the OR of the requests of the channels in native mode. It is forced to 0 while command bit 10 (interrupt disable) is set.
- R11: cfg_rdata is updated on the clock edge that samples cfg_rd and holds its value otherwise. Dwords that are not implemented read 0.
- R12: Only bits 0, 2 and 10 of the command word (dword 1, bits [15:0]) are writable. The interrupt dword (dword 15) reads {16'h0, 8'h01, line}, where line is a writable byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads all defaults |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Dword index into configuration space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| irq_pri | input | 1 | Primary channel interrupt request |
| irq_sec | input | 1 | Secondary channel interrupt request |
| pri_cmd_base | output | IO_AW | Primary command block decode base |
| pri_ctl_base | output | IO_AW | Primary control block decode base |
| sec_cmd_base | output | IO_AW | Secondary command block decode base |
| sec_ctl_base | output | IO_AW | Secondary control block decode base |
| dma_base | output | IO_AW | Bus-master DMA decode base |
| leg_irq_pri | output | 1 | Primary legacy interrupt level |
| leg_oe_pri | output | 1 | Drive enable for the primary legacy line |
| leg_irq_sec | output | 1 | Secondary legacy interrupt level |
| leg_oe_sec | output | 1 | Drive enable for the secondary legacy line |
| inta | output | 1 | Shared native interrupt request |

## Verification
Base-register writes are issued before and after each mode switch, and the channels are switched one at a time. This shows that a hidden register kept its reset value and that the two channels are gated independently. All-ones writes show the size masking and the read-only bit 0. Single-byte writes separate the byte lanes. Switching a channel back to compatibility mode and then to native mode again shows that a programmed value survives while hidden. Interrupt requests are applied with one channel in each mode and with the interrupt-disable bit both set and clear, which tells the legacy path apart from the shared path.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

  localparam int ADDR_W  = 6;
  localparam int NUM_BAR = 5;

  localparam logic [ADDR_W-1:0] DW_ID    = 6'd0;
  localparam logic [ADDR_W-1:0] DW_CMD   = 6'd1;
  localparam logic [ADDR_W-1:0] DW_CLASS = 6'd2;
  localparam logic [ADDR_W-1:0] DW_BAR0  = 6'd4;
  localparam logic [ADDR_W-1:0] DW_INTR  = 6'd15;

  localparam logic [15:0] CMD_WMASK = 16'h0405;

  // byte enables expanded into a bit mask
  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // writable address bits of an I/O BAR: [aw-1:sz_log2]
  function automatic logic [31:0] io_bar_mask(input int aw, input int sz_log2);
    logic [63:0] hi;
    logic [63:0] lo;
    hi = (64'd1 << aw) - 64'd1;
    lo = (64'd1 << sz_log2) - 64'd1;
    return 32'(hi & ~lo);
  endfunction

  // merged BAR value after a byte-enabled write; bit 0 marks I/O space
  function automatic logic [31:0] bar_next(input logic [31:0] cur,
                                           input logic [31:0] wdata,
                                           input logic [3:0]  be,
                                           input logic [31:0] wmask);
    logic [31:0] m;
    m = be_to_mask(be) & wmask;
    return (((cur & ~m) | (wdata & m)) & wmask) | 32'h1;
  endfunction

  function automatic int bar_size_log2(input int idx);
    case (idx)
      0, 2:    return 3;
      1, 3:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] bar_rst(input int idx);
    case (idx)
      0:       return 32'h0000_01F1;
      1:       return 32'h0000_03F5;
      2:       return 32'h0000_0171;
      3:       return 32'h0000_0375;
      default: return 32'h0000_CC01;
    endcase
  endfunction

  function automatic logic [31:0] bar_legacy(input int idx);
    case (idx)
      0:       return 32'h0000_01F0;
      1:       return 32'h0000_03F4;
      2:       return 32'h0000_0170;
      3:       return 32'h0000_0374;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/ide_bar_reg.sv
module ide_bar_reg
  import ide_cfg_pkg::*;
#(
  parameter int          IO_AW     = 16,
  parameter int          SIZE_LOG2 = 3,
  parameter logic [31:0] RST_VAL   = 32'h1,
  parameter logic [31:0] LEG_BASE  = 32'h0,
  parameter bit          GATED     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [31:0]      wdata,
  input  logic [3:0]       be,
  input  logic             native,
  output logic [31:0]      rd_val,
  output logic [IO_AW-1:0] io_base
);
  localparam logic [31:0] WMASK = io_bar_mask(IO_AW, SIZE_LOG2);

  logic [31:0] bar_q;
  logic        visible;
  logic        wr_ok;

  if (GATED) begin : g_gated
    assign visible = native;
  end else begin : g_open
    assign visible = 1'b1;
  end

  assign wr_ok = wr_sel && visible;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bar_q <= RST_VAL;
    else if (wr_ok)
      bar_q <= bar_next(bar_q, wdata, be, WMASK);
  end

  assign rd_val  = visible ? bar_q : 32'h0;
  assign io_base = visible ? IO_AW'(bar_q & WMASK) : IO_AW'(LEG_BASE);

  // R2
  bar_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !visible) |=> $stable(bar_q));

  // R7
  bar_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(bar_q));

endmodule

// File: rtl/ide_progif_reg.sv
module ide_progif_reg #(
  parameter logic [7:0] RST = 8'h8A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic [7:0] wbyte,
  output logic [7:0] progif_q,
  output logic       native_pri,
  output logic       native_sec
);
  localparam logic [7:0] WMASK = {5'b0, RST[3], 1'b0, RST[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      progif_q <= RST;
    else if (wr_sel)
      progif_q <= (progif_q & ~WMASK) | (wbyte & WMASK);
  end

  assign native_pri = progif_q[0];
  assign native_sec = progif_q[2];

  // R6
  progif_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> $stable(progif_q & ~WMASK));

endmodule

// File: rtl/ide_irq_steer.sv
module ide_irq_steer (
  input  logic [1:0] native,
  input  logic [1:0] req,
  input  logic       intx_dis,
  output logic [1:0] leg_irq,
  output logic [1:0] leg_oe,
  output logic       inta
);
  logic [1:0] to_native;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    assign leg_oe[c]    = !native[c];
    assign leg_irq[c]   = !native[c] && req[c];
    assign to_native[c] = native[c] && req[c];
  end

  assign inta = (|to_native) && !intx_dis;

endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
  import ide_cfg_pkg::*;
#(
  parameter int          IO_AW      = 16,
  parameter logic [15:0] VEN_ID     = 16'h1AB0,
  parameter logic [15:0] DEV_ID     = 16'h0E1D,
  parameter logic [7:0]  REV        = 8'h06,
  parameter logic [7:0]  PROGIF_RST = 8'h8A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [5:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              irq_pri,
  input  logic              irq_sec,
  output logic [IO_AW-1:0]  pri_cmd_base,
  output logic [IO_AW-1:0]  pri_ctl_base,
  output logic [IO_AW-1:0]  sec_cmd_base,
  output logic [IO_AW-1:0]  sec_ctl_base,
  output logic [IO_AW-1:0]  dma_base,
  output logic              leg_irq_pri,
  output logic              leg_oe_pri,
  output logic              leg_irq_sec,
  output logic              leg_oe_sec,
  output logic              inta
);
  logic [7:0]       progif_q;
  logic [1:0]       native;
  logic [15:0]      cmd_q;
  logic [7:0]       int_line_q;
  logic [31:0]      bar_rd   [NUM_BAR];
  logic [IO_AW-1:0] bar_base [NUM_BAR];
  logic [NUM_BAR-1:0] bar_wr;
  logic [31:0]      rd_mux;
  logic [1:0]       leg_irq;
  logic [1:0]       leg_oe;
  logic             intx_dis;
  logic             progif_wr;
  logic [15:0]      cmd_m;

  // programming-interface byte
  assign progif_wr = cfg_wr && (cfg_addr == DW_CLASS) && cfg_be[1];

  ide_progif_reg #(.RST(PROGIF_RST)) u_progif (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (progif_wr),
    .wbyte      (cfg_wdata[15:8]),
    .progif_q   (progif_q),
    .native_pri (native[0]),
    .native_sec (native[1])
  );

  // base address registers
  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    logic nat_i;
    assign bar_wr[i] = cfg_wr && (cfg_addr == 6'(DW_BAR0 + i));
    assign nat_i     = (i < 2) ? native[0] : native[1];

    ide_bar_reg #(
      .IO_AW     (IO_AW),
      .SIZE_LOG2 (bar_size_log2(i)),
      .RST_VAL   (bar_rst(i)),
      .LEG_BASE  (bar_legacy(i)),
      .GATED     (i < 4)
    ) u_bar (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (bar_wr[i]),
      .wdata   (cfg_wdata),
      .be      (cfg_be),
      .native  (nat_i),
      .rd_val  (bar_rd[i]),
      .io_base (bar_base[i])
    );
  end

  assign pri_cmd_base = bar_base[0];
  assign pri_ctl_base = bar_base[1];
  assign sec_cmd_base = bar_base[2];
  assign sec_ctl_base = bar_base[3];
  assign dma_base     = bar_base[4];

  // command word and interrupt line
  assign cmd_m = be_to_mask(cfg_be)[15:0] & CMD_WMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= 16'h0;
      int_line_q <= 8'h0;
    end else if (cfg_wr) begin
      if (cfg_addr == DW_CMD)
        cmd_q <= (cmd_q & ~cmd_m) | (cfg_wdata[15:0] & cmd_m);
      if (cfg_addr == DW_INTR && cfg_be[0])
        int_line_q <= cfg_wdata[7:0];
    end
  end

  assign intx_dis = cmd_q[10];

  // read path
  always_comb begin
    rd_mux = 32'h0;
    case (cfg_addr)
      DW_ID:    rd_mux = {DEV_ID, VEN_ID};
      DW_CMD:   rd_mux = {16'h0, cmd_q};
      DW_CLASS: rd_mux = {8'h01, 8'h01, progif_q, REV};
      6'd4:     rd_mux = bar_rd[0];
      6'd5:     rd_mux = bar_rd[1];
      6'd6:     rd_mux = bar_rd[2];
      6'd7:     rd_mux = bar_rd[3];
      6'd8:     rd_mux = bar_rd[4];
      DW_INTR:  rd_mux = {16'h0, 8'h01, int_line_q};
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_rdata <= 32'h0;
    else if (cfg_rd)
      cfg_rdata <= rd_mux;
  end

  // interrupt steering
  ide_irq_steer u_irq (
    .native   (native),
    .req      ({irq_sec, irq_pri}),
    .intx_dis (intx_dis),
    .leg_irq  (leg_irq),
    .leg_oe   (leg_oe),
    .inta     (inta)
  );

  assign leg_irq_pri = leg_irq[0];
  assign leg_irq_sec = leg_irq[1];
  assign leg_oe_pri  = leg_oe[0];
  assign leg_oe_sec  = leg_oe[1];

  // R9
  leg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    native[0] |-> (!leg_oe_pri && !leg_irq_pri));

  // R10
  inta_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_dis |-> !inta);

  // R3
  leg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !native[1] |-> (sec_cmd_base == IO_AW'(32'h170) && sec_ctl_base == IO_AW'(32'h374)));

  // R2
  hidden_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == DW_BAR0 && !native[0]) |=> (cfg_rdata == 32'h0));

endmodule

// File: tb/ide_cfg_space_bench.sv
module ide_cfg_space_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = 6'd0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        irq_pri = 1'b0;
  logic        irq_sec = 1'b0;
  logic [15:0] pri_cmd_base, pri_ctl_base, sec_cmd_base, sec_ctl_base, dma_base;
  logic        leg_irq_pri, leg_oe_pri, leg_irq_sec, leg_oe_sec, inta;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  ide_cfg_space u_ide_cfg_space (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_pri(irq_pri), .irq_sec(irq_sec),
    .pri_cmd_base(pri_cmd_base), .pri_ctl_base(pri_ctl_base),
    .sec_cmd_base(sec_cmd_base), .sec_ctl_base(sec_ctl_base),
    .dma_base(dma_base), .leg_irq_pri(leg_irq_pri), .leg_oe_pri(leg_oe_pri),
    .leg_irq_sec(leg_irq_sec), .leg_oe_sec(leg_oe_sec), .inta(inta)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: read data is due one edge after the strobe
  always @(posedge clk) rd_d <= cfg_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 actual unexpected-read expected none");
      end else begin
        chk(cfg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic set_irq(input logic p, input logic s);
    @(negedge clk);
    irq_pri = p; irq_sec = s;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(cfg_rdata, 32'h0, "R11 reset rdata");
    rd(6'd2, 32'h0101_8A06, "R1 class dword");
    rd(6'd0, 32'h0E1D_1AB0, "R1 id dword");
    rd(6'd4, 32'h0, "R2 bar0 hidden");
    rd(6'd7, 32'h0, "R2 bar3 hidden");
    rd(6'd8, 32'h0000_CC01, "R5 dma reset");
    chk(32'(pri_cmd_base), 32'h1F0, "R3 pri cmd");
    chk(32'(pri_ctl_base), 32'h3F4, "R3 pri ctl");
    chk(32'(sec_cmd_base), 32'h170, "R3 sec cmd");
    chk(32'(sec_ctl_base), 32'h374, "R3 sec ctl");
    chk(32'(dma_base), 32'hCC00, "R5 dma base");
    // write before switch is dropped
    wr(6'd4, 32'h0000_1234, 4'hF);
    rd(6'd4, 32'h0, "R2 write dropped read");
    chk(32'(pri_cmd_base), 32'h1F0, "R2 base unchanged");
    // primary to native only
    wr(6'd2, 32'h0000_0100, 4'b0010);
    rd(6'd2, 32'h0101_8B06, "R6 primary native");
    rd(6'd4, 32'h0000_01F1, "R8 pri cmd default");
    rd(6'd5, 32'h0000_03F5, "R8 pri ctl default");
    rd(6'd6, 32'h0, "R2 sec still hidden");
    chk(32'(sec_cmd_base), 32'h170, "R3 sec fixed while pri native");
    // native writes, size masking
    wr(6'd4, 32'hFFFF_FFFF, 4'hF);
    rd(6'd4, 32'h0000_FFF9, "R4 cmd mask");
    chk(32'(pri_cmd_base), 32'hFFF8, "R4 cmd base");
    wr(6'd5, 32'hFFFF_FFFF, 4'hF);
    rd(6'd5, 32'h0000_FFFD, "R4 ctl mask");
    chk(32'(pri_ctl_base), 32'hFFFC, "R4 ctl base");
    // byte lanes
    wr(6'd4, 32'h0000_12AB, 4'b0001);
    rd(6'd4, 32'h0000_FFA9, "R7 low byte");
    wr(6'd4, 32'h0000_1200, 4'b0010);
    rd(6'd4, 32'h0000_12A9, "R7 second byte");
    chk(32'(pri_cmd_base), 32'h12A8, "R7 base after lanes");
    // DMA base
    wr(6'd8, 32'h0000_D00F, 4'hF);
    rd(6'd8, 32'h0000_D001, "R5 dma write");
    wr(6'd8, 32'hFFFF_0000, 4'b1100);
    rd(6'd8, 32'h0000_D001, "R5 dma upper ro");
    chk(32'(dma_base), 32'hD000, "R5 dma base out");
    // interrupts: primary native, secondary legacy
    set_irq(1'b1, 1'b0);
    chk({31'h0, inta}, 32'h1, "R10 inta from pri");
    chk({30'h0, leg_oe_pri, leg_irq_pri}, 32'h0, "R9 pri released");
    chk({30'h0, leg_oe_sec, leg_irq_sec}, 32'h2, "R9 sec idle driven");
    set_irq(1'b0, 1'b1);
    chk({30'h0, leg_oe_sec, leg_irq_sec}, 32'h3, "R9 sec legacy irq");
    chk({31'h0, inta}, 32'h0, "R10 sec not shared");
    set_irq(1'b1, 1'b1);
    wr(6'd1, 32'h0000_0400, 4'b0010);
    #1;
    chk({31'h0, inta}, 32'h0, "R10 intx disabled");
    rd(6'd1, 32'h0000_0400, "R12 cmd bit10");
    wr(6'd1, 32'hFFFF_FFFF, 4'hF);
    rd(6'd1, 32'h0000_0405, "R12 cmd mask");
    wr(6'd1, 32'h0, 4'hF);
    #1;
    chk({31'h0, inta}, 32'h1, "R10 intx enabled");
    // primary back to legacy, indicators read-only
    wr(6'd2, 32'h0000_7000, 4'b0010);
    rd(6'd2, 32'h0101_8A06, "R6 ro bits kept");
    rd(6'd4, 32'h0, "R2 hidden after switch back");
    wr(6'd4, 32'h0000_4440, 4'hF);
    chk(32'(pri_cmd_base), 32'h1F0, "R3 fixed after switch back");
    #1;
    chk({30'h0, leg_oe_pri, leg_irq_pri}, 32'h3, "R9 pri legacy irq");
    chk({31'h0, inta}, 32'h0, "R10 no native requester");
    // both native: kept value and secondary default
    wr(6'd2, 32'h0000_FF00, 4'b0010);
    rd(6'd2, 32'h0101_8F06, "R6 both native");
    rd(6'd4, 32'h0000_12A9, "R2 value kept while hidden");
    rd(6'd6, 32'h0000_0171, "R8 sec cmd default");
    rd(6'd7, 32'h0000_0375, "R8 sec ctl default");
    chk(32'(sec_ctl_base), 32'h374, "R4 sec ctl native base");
    set_irq(1'b0, 1'b1);
    chk({31'h0, inta}, 32'h1, "R10 inta from sec");
    chk({30'h0, leg_oe_sec, leg_irq_sec}, 32'h0, "R9 sec released");
    // interrupt line, unimplemented dword, hold
    wr(6'd15, 32'hFFFF_FF0E, 4'hF);
    rd(6'd15, 32'h0000_010E, "R12 int dword");
    wr(6'd3, 32'hFFFF_FFFF, 4'hF);
    rd(6'd3, 32'h0, "R11 unimplemented");
    wr(6'd15, 32'h0000_0033, 4'h1);
    @(negedge clk);
    chk(cfg_rdata, 32'h0, "R11 rdata holds");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 actual pending %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule